// File: doc/BRIEF.md
# Rotary Encoder Serial Readout with Magnet Alignment Diagnostic

This block is the digital output stage of a magnetic rotary position sensor. An upstream front end delivers a 10-bit angle word, a 10-bit magnet displacement amplitude and two field-strength indicator bits. An external host frames each read with an active-low chip select (`cs_n`) and clocks the word out over `sclk`, most significant bit first. All three host pins are asynchronous. Each passes through a two-stage synchroniser into the system clock domain, and edges are detected on the synchronised copies.

A sticky diagnostic mode helps centre the magnet over the die. The host holds `prog` high for a programmable number of system clocks, drops `cs_n`, and keeps `prog` high for a further programmable number of clocks. After that the block latches into alignment mode. Every later frame then carries the displacement amplitude in place of the angle. Both indicator outputs also change meaning: they go high together when the amplitude is above a limit and stay low when the magnet is centred. Only the synchronous power-on reset leaves this mode.

Top module: `enc_ssi_readout`

## Requirements
- R1: While `rst` is high and after it is released, `align_active`, `sdo_oe`, `sdo`, `mag_inc` and `mag_dec` all read 0.
- R2: `sdo_oe` is 1 exactly while the synchronised `cs_n` is low, three system clocks after the pin, with `cs_n` idle high. While `sdo_oe` is 0, `sdo` reads 0. The 0 on `sdo_oe` stands for high impedance at the pad.
- R3: Within a frame, each rising `sclk` edge presents the next payload bit on `sdo`. The first rising edge gives bit 9 and the tenth gives bit 0. Any further rising edges in the same frame give 0.
- R4: The payload is captured on the `cs_n` falling edge. Changes to `angle` or `amp` during the frame do not alter the bits shifted out.
- R5: In normal mode the payload is `angle`, and `mag_inc`/`mag_dec` repeat `fld_inc`/`fld_dec` one system clock later.
- R6: Alignment mode is entered under two conditions. First, `cs_n` falls while `prog` has been high for at least `SETUP_CYC` clocks. Second, `prog` then stays high for `HOLD_CYC` more clocks. `align_active` then reads 1.
- R7: A `cs_n` falling edge whose `prog` setup is shorter than `SETUP_CYC` is ignored. The mode stays normal and later frames carry the angle.
- R8: If `prog` drops before `HOLD_CYC` clocks have passed after the qualifying edge, entry is abandoned and the mode stays normal.
- R9: Once `align_active` is 1, it stays 1 whatever `cs_n`, `sclk` and `prog` do, until `rst`.
- R10: In alignment mode, frames whose `cs_n` falling edge comes after entry carry `amp` as the payload.
- R11: In alignment mode, `mag_inc` and `mag_dec` both read 1 when `amp` > `ALIGN_LIMIT` (32). Both read 0 when `amp` <= 32, so 32 gives 0 and 33 gives 1. `fld_inc`/`fld_dec` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cs_n | input | 1 | Asynchronous active-low frame select |
| sclk | input | 1 | Asynchronous serial shift clock |
| prog | input | 1 | Asynchronous alignment-arm pin |
| angle | input | 10 | Angle word from the front end |
| amp | input | 10 | Displacement amplitude from the front end |
| fld_inc | input | 1 | Field-increase indicator from the front end |
| fld_dec | input | 1 | Field-decrease indicator from the front end |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| mag_inc | output | 1 | Field-increase flag output |
| mag_dec | output | 1 | Field-decrease flag output |
| align_active | output | 1 | Alignment mode latch state |

## Verification
Some rules are checked on every cycle. These are the stickiness of the mode latch, the threshold-driven flags in alignment mode, the pass-through flags in normal mode, and the three-clock relation between `cs_n` and `sdo_oe` together with `sdo` staying quiet while disabled. Other behaviour appears only through the bench's frame scenarios. This includes the bit order and padding inside a frame, and the capture of the payload at the select edge. It also includes whether an arming attempt is accepted or rejected for short setup or short hold, and the payload swap in frames after entry.

// File: rtl/enc_ssi_pkg.sv
package enc_ssi_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_HOLD   = 2'd1,
    MODE_ALIGN  = 2'd2
  } mode_e;
endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/enc_mode_ctl.sv
module enc_mode_ctl
  import enc_ssi_pkg::*;
#(
  parameter int SETUP_CYC = 100,
  parameter int HOLD_CYC  = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic prog_s,
  input  logic cs_fall,
  output logic align
);
  localparam int SW = $clog2(SETUP_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);

  mode_e         state;
  logic [SW-1:0] setup_cnt;
  logic [HW-1:0] hold_cnt;

  // Saturating count of consecutive synchronised prog-high clocks
  always_ff @(posedge clk) begin
    if (rst || !prog_s)                 setup_cnt <= '0;
    else if (setup_cnt != SW'(SETUP_CYC)) setup_cnt <= setup_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= MODE_NORMAL;
      hold_cnt <= '0;
    end else begin
      case (state)
        MODE_NORMAL: begin
          hold_cnt <= '0;
          if (cs_fall && prog_s && setup_cnt == SW'(SETUP_CYC)) state <= MODE_HOLD;
        end
        MODE_HOLD: begin
          if (!prog_s) begin
            state <= MODE_NORMAL;
          end else if (hold_cnt == HW'(HOLD_CYC - 1)) begin
            state <= MODE_ALIGN;
          end else begin
            hold_cnt <= hold_cnt + 1'b1;
          end
        end
        MODE_ALIGN: state <= MODE_ALIGN;
        default:    state <= MODE_NORMAL;
      endcase
    end
  end

  assign align = (state == MODE_ALIGN);
endmodule

// File: rtl/enc_ssi_tx.sv
module enc_ssi_tx #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              cs_fall,
  input  logic              sclk_rise,
  input  logic [DATA_W-1:0] payload,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [DATA_W-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      sdo_oe <= !cs_s;
      if (cs_fall) begin
        shadow <= payload;
        sdo    <= 1'b0;
      end else if (cs_s) begin
        sdo    <= 1'b0;
      end else if (sclk_rise) begin
        sdo    <= shadow[DATA_W-1];
        shadow <= {shadow[DATA_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/enc_ssi_readout.sv
module enc_ssi_readout #(
  parameter int DATA_W      = 10,
  parameter int ALIGN_LIMIT = 32,
  parameter int SETUP_CYC   = 100,
  parameter int HOLD_CYC    = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              prog,
  input  logic [DATA_W-1:0] angle,
  input  logic [DATA_W-1:0] amp,
  input  logic              fld_inc,
  input  logic              fld_dec,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              mag_inc,
  output logic              mag_dec,
  output logic              align_active
);
  logic [2:0] pins_s;
  logic cs_s, sclk_s, prog_s;
  logic cs_prev, sclk_prev;
  logic cs_fall, sclk_rise;
  logic over_limit;
  logic [DATA_W-1:0] payload;

  enc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, prog}), .q(pins_s)
  );
  assign cs_s   = pins_s[2];
  assign sclk_s = pins_s[1];
  assign prog_s = pins_s[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      cs_prev   <= cs_s;
      sclk_prev <= sclk_s;
    end
  end
  assign cs_fall   = cs_prev && !cs_s;
  assign sclk_rise = !sclk_prev && sclk_s;

  enc_mode_ctl #(.SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)) u_mode (
    .clk(clk), .rst(rst), .prog_s(prog_s), .cs_fall(cs_fall), .align(align_active)
  );

  assign payload    = align_active ? amp : angle;
  assign over_limit = (amp > DATA_W'(ALIGN_LIMIT));

  enc_ssi_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .cs_s(cs_s), .cs_fall(cs_fall), .sclk_rise(sclk_rise),
    .payload(payload), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_inc <= 1'b0;
      mag_dec <= 1'b0;
    end else if (align_active) begin
      mag_inc <= over_limit;
      mag_dec <= over_limit;
    end else begin
      mag_inc <= fld_inc;
      mag_dec <= fld_dec;
    end
  end
endmodule

// File: rtl/enc_ssi_readout_chk.sv
module enc_ssi_readout_chk #(
  parameter int DATA_W      = 10,
  parameter int ALIGN_LIMIT = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic [DATA_W-1:0] amp,
  input logic              fld_inc,
  input logic              fld_dec,
  input logic              sdo,
  input logic              sdo_oe,
  input logic              mag_inc,
  input logic              mag_dec,
  input logic              align_active
);
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 1'b1;
  end

  assert_oe_tracks_cs_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd4) |-> (sdo_oe == !$past(cs_n, 3)));

  assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 3'd0 && !sdo_oe) |-> !sdo);

  assert_mode_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    align_active |=> align_active);

  assert_flags_high_R11: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 3'd0 && $past(align_active) && $past(amp) > DATA_W'(ALIGN_LIMIT))
      |-> (mag_inc && mag_dec));

  assert_flags_low_R11: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 3'd0 && $past(align_active) && $past(amp) <= DATA_W'(ALIGN_LIMIT))
      |-> (!mag_inc && !mag_dec));

  assert_flags_follow_R5: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 3'd0 && !$past(align_active))
      |-> (mag_inc == $past(fld_inc) && mag_dec == $past(fld_dec)));
endmodule

bind enc_ssi_readout enc_ssi_readout_chk #(.DATA_W(DATA_W), .ALIGN_LIMIT(ALIGN_LIMIT)) u_chk (.*);

// File: tb/enc_ssi_readout_bench.sv
module enc_ssi_readout_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 8;

  logic clk = 0, rst = 1, cs_n = 1, sclk = 0, prog = 0;
  logic [9:0] angle = '0, amp = '0;
  logic fld_inc = 0, fld_dec = 0;
  logic sdo, sdo_oe, mag_inc, mag_dec, align_active;
  int nchk = 0, nbad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  enc_ssi_readout u_enc_ssi_readout (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .prog(prog),
    .angle(angle), .amp(amp), .fld_inc(fld_inc), .fld_dec(fld_dec),
    .sdo(sdo), .sdo_oe(sdo_oe), .mag_inc(mag_inc), .mag_dec(mag_dec),
    .align_active(align_active)
  );

  function automatic logic exp_flag(input logic al, input logic [9:0] a, input logic f);
    return al ? (a > 10'd32) : f;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Runs one frame of nbits clocks; optionally scrambles the inputs mid-frame
  task automatic frame(input int nbits, input bit scramble, output logic [15:0] word);
    word = '0;
    cs_n = 0; cyc(PH);
    chk("R2 oe in frame", sdo_oe, 1);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1; cyc(PH);
      word = {word[14:0], sdo};
      if (scramble && i == 0) begin angle = ~angle; amp = ~amp; end
      sclk = 0; cyc(PH);
    end
    cs_n = 1; cyc(PH);
    chk("R2 oe idle", sdo_oe, 0);
    chk("R2 sdo idle", sdo, 0);
  endtask

  task automatic arm(input int pre, input int post);
    prog = 1; cyc(pre);
    cs_n = 0; cyc(post);
    prog = 0; cyc(5);
    cs_n = 1; cyc(10);
  endtask

  task automatic flag_check(input string req);
    logic [9:0] a; logic fi, fd;
    a = amp; fi = fld_inc; fd = fld_dec;
    cyc(3);
    chk(req, mag_inc, exp_flag(align_active, a, fi));
    chk(req, mag_dec, exp_flag(align_active, a, fd));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      nbad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic [9:0] keep;
    void'($urandom(32'd7321));
    cyc(5);
    chk("R1 align", align_active, 0);
    chk("R1 oe", sdo_oe, 0);
    chk("R1 sdo", sdo, 0);
    chk("R1 inc", mag_inc, 0);
    rst = 0; cyc(4);
    chk("R1 after release", align_active, 0);

    // R5/R3: normal-mode frames and flag pass-through with random values
    for (int k = 0; k < 30; k++) begin
      angle = 10'($urandom); amp = 10'($urandom);
      fld_inc = 1'($urandom); fld_dec = 1'($urandom);
      flag_check("R5 flags");
      keep = angle;
      frame(10, 0, w);
      chk("R5 R3 payload angle", w[9:0], keep);
    end
    angle = 10'h2A5; frame(12, 0, w);
    chk("R3 padding", w[11:0], {10'h2A5, 2'b00});
    angle = 10'h3C1; keep = angle; frame(10, 1, w);
    chk("R4 capture", w[9:0], keep);

    // R7: short setup is ignored
    arm(30, 150);
    chk("R7 short setup", align_active, 0);
    angle = 10'h155; amp = 10'h0AA; frame(10, 0, w);
    chk("R7 payload stays angle", w[9:0], 10'h155);
    // R8: short hold is ignored
    arm(150, 30);
    chk("R8 short hold", align_active, 0);
    frame(10, 0, w);
    chk("R8 payload stays angle", w[9:0], 10'h155);
    // R6: proper entry
    arm(150, 150);
    chk("R6 entered", align_active, 1);

    // R10/R11: directed boundaries then random amplitudes
    fld_inc = 0; fld_dec = 0; amp = 10'd32; flag_check("R11 at 32");
    fld_inc = 1; fld_dec = 1; amp = 10'd32; flag_check("R11 fld ignored");
    amp = 10'd33; fld_inc = 0; fld_dec = 0; flag_check("R11 at 33");
    for (int k = 0; k < 25; k++) begin
      amp = (k % 3 == 0) ? 10'($urandom_range(0, 64)) : 10'($urandom);
      angle = 10'($urandom);
      fld_inc = 1'($urandom); fld_dec = 1'($urandom);
      flag_check("R11 flags");
      keep = amp;
      frame(10, (k % 5 == 0), w);
      chk("R10 payload amp", w[9:0], keep);
      if (k % 4 == 0) begin
        prog = 1'($urandom); cs_n = 0; cyc(6); cs_n = 1; prog = 0; cyc(6);
        chk("R9 persists", align_active, 1);
      end
    end
    chk("R9 persists end", align_active, 1);

    rst = 1; cyc(3); rst = 0; cyc(3);
    chk("R1 R9 reset clears", align_active, 0);
    angle = 10'h0F0; frame(10, 0, w);
    chk("R5 angle after reset", w[9:0], 10'h0F0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule